// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples a bank of general-purpose pins and raises a single interrupt request. The interrupt is built from per-pin trigger conditions. Software reaches the block over a plain synchronous register bus. Each transfer presents a word address, a write strobe and a write word, and the read word comes back in the same cycle. Every register holds one bit per pin, so one access can configure, drive or inspect all pins at once.

Each pin runs in one of three roles:

- **General input:** the pin is sampled through a two-stage synchronizer.
- **General output:** the pin drives a stored output level and asserts its output enable.
- **Interrupt input:** the synchronized level, inverted when negative polarity is chosen, feeds a pending bit. The trigger is either the level itself or a rising transition of the qualified signal.

Pending bits are visible to software. Edge-triggered pending bits are acknowledged by writing ones. Each pin's contribution to the interrupt line is gated by a mask, and the mask has separate set and clear write locations. The output level register keeps its content while a pin is an input, so a level can be loaded before the pin is turned into an output.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every output enable is 0, the interrupt line is low, the pending word (address 6) reads 0 and the mask word (address 8) reads all ones (1 = masked).
- R2: A pin drives its output enable only when its direction bit (address 3, 1 = output) is 1 and its interrupt-role bit (address 2, 1 = interrupt input) is 0.
- R3: The output level register (address 4) appears on the pad output of every pin and keeps its written value while the pin is an input, so the preloaded level is driven as soon as the direction bit is set.
- R4: Reading address 5 returns the pad input levels as they were two clock edges earlier (two-flop synchronizer); a change is not visible after only one edge.
- R5: A pin in level-trigger mode (address 1 bit = 0) with interrupt role has a pending bit that follows the qualified level one edge after the synchronized sample; writing its acknowledge bit does not clear it while the level persists.
- R6: A polarity bit (address 0) of 1 inverts the pin before trigger detection, giving active-low level and falling-edge behaviour; 0 gives active-high and rising-edge behaviour.
- R7: A pin in edge-trigger mode (address 1 bit = 1) with interrupt role sets its pending bit on a qualified rising transition and holds it after the input returns, until a 1 is written to its bit at the acknowledge address 7; 0 bits written there have no effect.
- R8: When a qualified edge and an acknowledge of the same pin fall in the same cycle, the pending bit ends up set.
- R9: Writing address 8 masks every pin whose written bit is 0 and leaves pins with written 1 unchanged; writing a 1 bit to address 9 unmasks that pin; address 8 reads back the mask state.
- R10: The interrupt line is high exactly when some pin has its pending bit set, is unmasked and is in interrupt role; a pin outside the interrupt role has a pending bit of 0 one edge after leaving it.
- R11: Addresses 0 to 4 read back the last value written; the write-only addresses 7 and 9 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | N_PINS | Write data, one bit per pin |
| bus_rdata | output | N_PINS | Read data for bus_addr, same cycle |
| pad_in | input | N_PINS | Asynchronous pin input levels |
| pad_out | output | N_PINS | Pin output levels |
| pad_oe | output | N_PINS | Pin output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong pending bit shows up on the pending read and on the interrupt line one edge after the synchronized sample. That is three edges after a pad changes. The bench therefore samples exactly there and again after the input returns, which separates level from edge behaviour. A corrupted mask or role bit changes the interrupt line in the very next cycle. It also reads back wrongly from address 8 or 2. A broken synchronizer depth is caught by reading the input word after one edge and again after two.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 4;

  // Word addresses of the register bus
  typedef enum logic [REG_AW-1:0] {
    RA_POL    = 4'd0,  // polarity, 1 = inverted
    RA_TRIG   = 4'd1,  // 1 = edge, 0 = level
    RA_MODE   = 4'd2,  // 1 = interrupt input, 0 = general I/O
    RA_DIR    = 4'd3,  // 1 = output
    RA_OUTV   = 4'd4,  // output level
    RA_INLVL  = 4'd5,  // synchronized input, read only
    RA_PEND   = 4'd6,  // pending status, read only
    RA_ACK    = 4'd7,  // write one to clear pending
    RA_MASK   = 4'd8,  // write zero to mask
    RA_UNMASK = 4'd9   // write one to unmask
  } reg_addr_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic              we,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      lvl,
  input  logic [N-1:0]      pend,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      trig_q,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      outv_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      ack
);
  logic wr_pol, wr_trig, wr_mode, wr_dir, wr_outv, wr_ack, wr_mask, wr_unmask;
  logic [N-1:0] pol_d, trig_d, mode_d, dir_d, outv_d, mask_d;

  // write decode
  always_comb begin
    wr_pol    = we && (addr == RA_POL);
    wr_trig   = we && (addr == RA_TRIG);
    wr_mode   = we && (addr == RA_MODE);
    wr_dir    = we && (addr == RA_DIR);
    wr_outv   = we && (addr == RA_OUTV);
    wr_ack    = we && (addr == RA_ACK);
    wr_mask   = we && (addr == RA_MASK);
    wr_unmask = we && (addr == RA_UNMASK);
  end

  // next state
  always_comb begin
    pol_d  = wr_pol  ? wdata : pol_q;
    trig_d = wr_trig ? wdata : trig_q;
    mode_d = wr_mode ? wdata : mode_q;
    dir_d  = wr_dir  ? wdata : dir_q;
    outv_d = wr_outv ? wdata : outv_q;
    mask_d = mask_q;
    if (wr_mask)   mask_d = mask_q | ~wdata;
    if (wr_unmask) mask_d = mask_q & ~wdata;
    ack    = wr_ack ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
      mode_q <= '0;
      dir_q  <= '0;
      outv_q <= '0;
      mask_q <= '1;
    end else begin
      if (wr_pol)               pol_q  <= pol_d;
      if (wr_trig)              trig_q <= trig_d;
      if (wr_mode)              mode_q <= mode_d;
      if (wr_dir)               dir_q  <= dir_d;
      if (wr_outv)              outv_q <= outv_d;
      if (wr_mask || wr_unmask) mask_q <= mask_d;
    end
  end

  // read mux, same cycle
  always_comb begin
    case (addr)
      RA_POL:   rdata = pol_q;
      RA_TRIG:  rdata = trig_q;
      RA_MODE:  rdata = mode_q;
      RA_DIR:   rdata = dir_q;
      RA_OUTV:  rdata = outv_q;
      RA_INLVL: rdata = lvl;
      RA_PEND:  rdata = pend;
      RA_MASK:  rdata = mask_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend_q,
  output logic         irq
);
  logic [N-1:0] qual;
  logic [N-1:0] prev_q;
  logic [N-1:0] pend_d;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic hit;
    always_comb begin
      qual[i] = lvl[i] ^ pol[i];
      hit     = qual[i] & ~prev_q[i];
      if (!mode[i])     pend_d[i] = 1'b0;
      else if (trig[i]) pend_d[i] = hit | (pend_q[i] & ~ack[i]);
      else              pend_d[i] = qual[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= qual;
      pend_q <= pend_d;
    end
  end

  assign irq = |(pend_q & ~mask & mode);
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int N_PINS = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [gpio_irq_pkg::REG_AW-1:0] bus_addr,
  input  logic                            bus_we,
  input  logic [N_PINS-1:0]               bus_wdata,
  output logic [N_PINS-1:0]               bus_rdata,
  input  logic [N_PINS-1:0]               pad_in,
  output logic [N_PINS-1:0]               pad_out,
  output logic [N_PINS-1:0]               pad_oe,
  output logic                            irq_out
);
  logic              rst_sync_n;
  logic [N_PINS-1:0] lvl;
  logic [N_PINS-1:0] pol_q, trig_q, mode_q, dir_q, outv_q, mask_q, ack;
  logic [N_PINS-1:0] pend_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (lvl)
  );

  gpio_regfile #(.N(N_PINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .lvl    (lvl),
    .pend   (pend_q),
    .pol_q  (pol_q),
    .trig_q (trig_q),
    .mode_q (mode_q),
    .dir_q  (dir_q),
    .outv_q (outv_q),
    .mask_q (mask_q),
    .ack    (ack)
  );

  gpio_irq_unit #(.N(N_PINS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl    (lvl),
    .pol    (pol_q),
    .trig   (trig_q),
    .mode   (mode_q),
    .mask   (mask_q),
    .ack    (ack),
    .pend_q (pend_q),
    .irq    (irq_out)
  );

  assign pad_out = outv_q;
  assign pad_oe  = dir_q & ~mode_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [REG_AW-1:0] bus_addr,
  input logic              bus_we,
  input logic [N-1:0]      bus_wdata,
  input logic              irq_out,
  input logic [N-1:0]      mode_q,
  input logic [N-1:0]      trig_q,
  input logic [N-1:0]      mask_q,
  input logic [N-1:0]      pend_q
);
  logic [N-1:0] ack_w;
  assign ack_w = (bus_we && bus_addr == RA_ACK) ? bus_wdata : '0;

  // R7: unacknowledged edge pending bits stay set
  p_edge_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (($past(pend_q & trig_q & mode_q & ~ack_w) & trig_q & mode_q & ~pend_q) == '0));

  // R9: zero bits written to the mask location become masked
  p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == RA_MASK) |=> ((~mask_q & ~$past(bus_wdata)) == '0));

  // R9: one bits written to the unmask location become unmasked
  p_unmask_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == RA_UNMASK) |=> ((mask_q & $past(bus_wdata)) == '0));

  // R10: the interrupt line needs at least one unmasked pin
  p_irq_unmasked_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_out |-> !(&mask_q));

  // R10: pins outside the interrupt role carry no pending bit
  p_nonirq_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pend_q & ~$past(mode_q)) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N_PINS)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .irq_out    (irq_out),
  .mode_q     (mode_q),
  .trig_q     (trig_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam int N = 32;
  localparam logic [3:0] A_POL = 4'd0, A_TRIG = 4'd1, A_MODE = 4'd2, A_DIR = 4'd3,
                         A_OUTV = 4'd4, A_INLVL = 4'd5, A_PEND = 4'd6, A_ACK = 4'd7,
                         A_MASK = 4'd8, A_UNMASK = 4'd9;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [3:0]   bus_addr;
  logic         bus_we;
  logic [N-1:0] bus_wdata;
  logic [N-1:0] bus_rdata;
  logic [N-1:0] pad_in;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;
  logic         irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negative edge; returns at the next negative edge
  task automatic bus_write(input logic [3:0] a, input logic [N-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [N-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // pad change -> pending visible after three edges
  task automatic wait_pend();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1 oe", pad_oe, '0);
    check("R1 irq", {31'd0, irq_out}, '0);
    bus_read(A_PEND, v);  check("R1 pend", v, '0);
    bus_read(A_MASK, v);  check("R1 mask", v, '1);
    bus_read(A_ACK, v);   check("R11 ack reads 0", v, '0);
  endtask

  task automatic t_io();
    logic [N-1:0] v;
    bus_write(A_OUTV, 32'hA5A5_0000);
    check("R3 oe while input", pad_oe, '0);
    check("R3 out held", pad_out, 32'hA5A5_0000);
    bus_write(A_DIR, 32'hFFFF_0000);
    check("R2 oe output", pad_oe, 32'hFFFF_0000);
    check("R3 preload driven", pad_out, 32'hA5A5_0000);
    bus_write(A_MODE, 32'h0001_0000);
    check("R2 irq role drops oe", pad_oe, 32'hFFFE_0000);
    bus_write(A_POL, 32'h1234_5678);
    bus_read(A_POL, v);    check("R11 pol readback", v, 32'h1234_5678);
    bus_read(A_DIR, v);    check("R11 dir readback", v, 32'hFFFF_0000);
    bus_read(A_UNMASK, v); check("R11 unmask reads 0", v, '0);
    bus_write(A_MODE, '0);
    bus_write(A_DIR, '0);
    bus_write(A_POL, '0);
  endtask

  task automatic t_input();
    logic [N-1:0] v;
    pad_in = 32'h0000_005A;
    @(posedge clk); @(negedge clk);
    bus_read(A_INLVL, v); check("R4 not after one edge", v, '0);
    @(posedge clk); @(negedge clk);
    bus_read(A_INLVL, v); check("R4 after two edges", v, 32'h0000_005A);
    pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    bus_write(A_POL, 32'h2);
    bus_write(A_TRIG, 32'h0);
    bus_write(A_UNMASK, 32'h3);
    bus_write(A_MODE, 32'h3);
    @(posedge clk); @(negedge clk);
    bus_read(A_PEND, v); check("R6 active-low level", v, 32'h2);
    check("R10 irq on", {31'd0, irq_out}, 32'h1);
    pad_in = 32'h1;
    wait_pend();
    bus_read(A_PEND, v); check("R5 active-high level", v, 32'h3);
    bus_write(A_ACK, 32'h3);
    bus_read(A_PEND, v); check("R5 ack ignored while level", v, 32'h3);
    pad_in = 32'h3;
    wait_pend();
    bus_read(A_PEND, v); check("R6 inactive high on inverted pin", v, 32'h1);
    pad_in = 32'h2;
    wait_pend();
    bus_read(A_PEND, v); check("R5 level drop clears", v, '0);
    check("R10 irq off", {31'd0, irq_out}, '0);
    bus_write(A_MODE, '0);
    bus_write(A_MASK, 32'hFFFF_FFFC);
  endtask

  task automatic t_edge();
    logic [N-1:0] v;
    pad_in = 32'h20;
    wait_pend();
    bus_write(A_POL, 32'h20);
    bus_write(A_TRIG, 32'h30);
    bus_write(A_MODE, 32'h30);
    bus_write(A_UNMASK, 32'h30);
    bus_read(A_PEND, v); check("R7 idle", v, '0);
    pad_in = 32'h30;
    wait_pend();
    bus_read(A_PEND, v); check("R7 rising sets", v, 32'h10);
    check("R10 irq edge", {31'd0, irq_out}, 32'h1);
    pad_in = 32'h20;
    wait_pend();
    bus_read(A_PEND, v); check("R7 held after release", v, 32'h10);
    bus_write(A_ACK, 32'hFFFF_FFEF);
    bus_read(A_PEND, v); check("R7 zero ack bit no effect", v, 32'h10);
    bus_write(A_ACK, 32'h10);
    bus_read(A_PEND, v); check("R7 ack clears", v, '0);
    pad_in = 32'h0;
    wait_pend();
    bus_read(A_PEND, v); check("R6 falling edge", v, 32'h20);
    bus_write(A_ACK, 32'h20);
    bus_read(A_PEND, v); check("R7 ack clears falling", v, '0);
  endtask

  task automatic t_collide();
    logic [N-1:0] v;
    pad_in = 32'h10;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_write(A_ACK, 32'h10);   // active at the edge that captures the hit
    bus_read(A_PEND, v); check("R8 set wins over ack", v, 32'h10);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    bus_write(A_MASK, 32'hFFFF_FFEF);
    bus_read(A_MASK, v); check("R9 zero bit masks", v, 32'hFFFF_FFDF);
    check("R9 masked irq low", {31'd0, irq_out}, '0);
    bus_read(A_PEND, v); check("R9 pending kept", v, 32'h10);
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, v); check("R9 one bits no change", v, 32'hFFFF_FFDF);
    bus_write(A_UNMASK, 32'h10);
    bus_read(A_MASK, v); check("R9 unmask", v, 32'hFFFF_FFCF);
    check("R10 irq after unmask", {31'd0, irq_out}, 32'h1);
    bus_write(A_MODE, 32'h20);
    check("R10 irq off outside role", {31'd0, irq_out}, '0);
    @(posedge clk); @(negedge clk);
    bus_read(A_PEND, v); check("R10 pending cleared outside role", v, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_io();
    t_input();
    t_level();
    t_edge();
    t_collide();
    t_mask();
    finish_run();
  end
endmodule